// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

A binary up-counter whose state bits all change together on the rising clock edge. The block has an active-low parallel load, an active-low clear and two count-enable inputs. The first enable gates counting only. The second enable gates counting and also the terminal-count carry. Because the carry depends on the second enable, stages can be chained without extra gates. The carry of one stage drives the second enable of the next stage, and a shared first enable starts or stops the whole chain.

A parameter chooses the clear style. In the asynchronous style, a low clear empties the counter at once. This also serves as the power-up reset. In the synchronous style, the clear takes effect at the next rising edge. You can then set a shorter count length by feeding an inverted decode of the last wanted value back into the clear.

Top module: `pcnt_counter`

## Requirements
- R1: With clear and load inactive and both enables high, each rising edge advances the count by one, and all bits change on that edge only.
- R2: If either enable is low (and clear and load are inactive), the count holds its value across the edge.
- R3: Counting wraps from the all-ones value (15 at the default width) to zero.
- R4: A low load_n at a rising edge copies din into the count, whatever levels the enables have.
- R5: With CLR_STYLE set to asynchronous (value 0), a low clr_n forces the count to zero at once, without any clock edge, and keeps it at zero over edges even while load_n is low.
- R6: With CLR_STYLE set to synchronous (value 1), a low clr_n leaves the count unchanged until the next rising edge, then sets it to zero. It overrides load and the enables.
- R7: The carry output is high exactly when the count is all ones and en_t is high. en_p has no effect on it.
- R8: Load and enable levels that change between edges have no effect. Only their levels at the rising edge select the operation.
- R9: In the synchronous style, driving clr_n from the inverted decode of count 9 gives a counter that cycles 0 through 9.
- R10: Two counters chained carry-to-en_t count as one 8-bit value, with the upper carry high only at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; style set by CLR_STYLE |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Parallel preset data |
| q | output | WIDTH | Current count |
| carry | output | 1 | High when count is all ones and en_t is high |

## Verification
The bench sweeps every preset value with every enable pair. This catches a design that lets an enable block the load. It also pairs every count value with every enable level on the carry, which exposes a carry that listens to en_p or fires below the top value. It moves load and enables between edges and pulls the asynchronous clear mid-cycle, so a design that latches levels outside the edge, or waits for a clock to clear, shows the wrong count. A synchronous clear fed back from a count of 9, and a two-stage chain run through its 255-to-0 rollover, catch a clear that acts one cycle off and a carry that ripples at the wrong count.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic {
        CLR_ASYNC = 1'b0,
        CLR_SYNC  = 1'b1
    } clr_style_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } cnt_ctrl_t;

endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
    import pcnt_pkg::*;
#(
    parameter clr_style_e CLR_STYLE = CLR_ASYNC
) (
    input  cnt_ctrl_t ctrl,
    output cnt_op_e   op
);
    localparam bit SYNC_CLR = (CLR_STYLE == CLR_SYNC);

    logic sync_clear;
    assign sync_clear = SYNC_CLR && !ctrl.clr_n;

    always_comb begin
        if (sync_clear)
            op = OP_CLEAR;
        else if (!ctrl.load_n)
            op = OP_LOAD;
        else if (ctrl.en_p && ctrl.en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/pcnt_state_reg.sv
module pcnt_state_reg
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             aclr_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_CLEAR: q_next = ZERO;
            OP_LOAD:  q_next = din;
            OP_COUNT: q_next = q_r + ONE;
            default:  q_next = q_r;
        endcase
    end

    always_ff @(posedge clk or negedge aclr_n) begin
        if (!aclr_n)
            q_r <= ZERO;
        else
            q_r <= q_next;
    end

    assign q = q_r;
endmodule

// File: rtl/pcnt_carry_gen.sv
module pcnt_carry_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry
);
    logic at_top;
    assign at_top = &q;
    assign carry  = en_t & at_top;
endmodule

// File: rtl/pcnt_counter.sv
module pcnt_counter
    import pcnt_pkg::*;
#(
    parameter int         WIDTH     = 4,
    parameter clr_style_e CLR_STYLE = CLR_ASYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    cnt_ctrl_t ctrl;
    cnt_op_e   op;
    logic      aclr_n;

    assign ctrl = '{clr_n: clr_n, load_n: load_n, en_p: en_p, en_t: en_t};

    generate
        if (CLR_STYLE == CLR_ASYNC) begin : g_aclr
            assign aclr_n = clr_n;
        end else begin : g_sclr
            assign aclr_n = 1'b1;
        end
    endgenerate

    pcnt_mode_dec #(.CLR_STYLE(CLR_STYLE)) u_dec (
        .ctrl (ctrl),
        .op   (op)
    );

    pcnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .aclr_n (aclr_n),
        .op     (op),
        .din    (din),
        .q      (q)
    );

    pcnt_carry_gen #(.WIDTH(WIDTH)) u_carry (
        .q     (q),
        .en_t  (en_t),
        .carry (carry)
    );

    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> q == $past(q) + ONE); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q)); // R2

    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (carry && en_p && load_n) |=> q == ZERO); // R3

    always_comb begin
        if (!en_t) AST_CARRY_T: assert (!carry); // R7
    end

    generate
        if (CLR_STYLE == CLR_ASYNC) begin : g_aclr_chk
            AST_ASYNC_CLEAR: assert property (@(posedge clk)
                !clr_n |-> q == ZERO); // R5
        end else begin : g_sclr_chk
            AST_SYNC_CLEAR: assert property (@(posedge clk)
                !clr_n |=> q == ZERO); // R6
        end
    endgenerate
endmodule

// File: tb/pcnt_counter_tb.sv
module pcnt_counter_tb;
    import pcnt_pkg::*;

    localparam int PERIOD = 20;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // asynchronous-clear unit
    logic       a_clr_n = 1'b0, a_load_n = 1'b1, a_p = 1'b0, a_t = 1'b0;
    logic [3:0] a_din = 4'd0, a_q;
    logic       a_co;
    // synchronous-clear unit
    logic       s_clr_n = 1'b0, s_load_n = 1'b1, s_p = 1'b0, s_t = 1'b0;
    logic [3:0] s_din = 4'd0, s_q;
    logic       s_co;
    // modulus-10 unit
    logic       m_init_n = 1'b0;
    logic       m_clr_n;
    logic [3:0] m_q;
    logic       m_co;
    // cascade pair
    logic       c_clr_n = 1'b0, c_en = 1'b0;
    logic [3:0] l_q, h_q;
    logic       l_co, h_co;

    assign m_clr_n = m_init_n & (m_q != 4'd9);

    pcnt_counter #(.WIDTH(4), .CLR_STYLE(CLR_ASYNC)) u_dut (
        .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .en_p(a_p), .en_t(a_t),
        .din(a_din), .q(a_q), .carry(a_co));

    pcnt_counter #(.WIDTH(4), .CLR_STYLE(CLR_SYNC)) u_sync (
        .clk(clk), .clr_n(s_clr_n), .load_n(s_load_n), .en_p(s_p), .en_t(s_t),
        .din(s_din), .q(s_q), .carry(s_co));

    pcnt_counter #(.WIDTH(4), .CLR_STYLE(CLR_SYNC)) u_mod (
        .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
        .din(4'd0), .q(m_q), .carry(m_co));

    pcnt_counter #(.WIDTH(4), .CLR_STYLE(CLR_ASYNC)) u_lo (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(c_en), .en_t(c_en),
        .din(4'd0), .q(l_q), .carry(l_co));

    pcnt_counter #(.WIDTH(4), .CLR_STYLE(CLR_ASYNC)) u_hi (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(c_en), .en_t(l_co),
        .din(4'd0), .q(h_q), .carry(h_co));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic a_load(input logic [3:0] v);
        a_din = v; a_load_n = 1'b0; a_p = 1'b0; a_t = 1'b0;
        tick();
        a_load_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 5000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R5: asynchronous clear before any clock edge
        #5;
        chk("R5 reset no clock", 32'(a_q), 32'd0);
        chk("R7 carry in reset", 32'(a_co), 32'd0);
        tick();
        a_clr_n = 1'b1; s_clr_n = 1'b1;
        chk("R6 sync clear at edge", 32'(s_q), 32'd0);

        // R4: load every value under every enable pair
        for (int v = 0; v < 16; v++) begin
            for (int pt = 0; pt < 4; pt++) begin
                a_din = 4'(v); a_load_n = 1'b0; a_p = pt[0]; a_t = pt[1];
                tick();
                chk("R4 load", 32'(a_q), 32'(v));
            end
        end

        // R1 and R3: count through the wrap
        a_load(4'd0);
        a_p = 1'b1; a_t = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            tick();
            chk("R1 R3 count", 32'(a_q), 32'(i % 16));
        end

        // R2: enable gating
        a_load(4'd5);
        a_p = 1'b0; a_t = 1'b1; tick(); chk("R2 p low", 32'(a_q), 32'd5);
        a_p = 1'b1; a_t = 1'b0; tick(); chk("R2 t low", 32'(a_q), 32'd5);
        a_p = 1'b0; a_t = 1'b0; tick(); chk("R2 both low", 32'(a_q), 32'd5);
        a_p = 1'b1; a_t = 1'b1; tick(); chk("R2 both high", 32'(a_q), 32'd6);

        // R7: carry over every count and enable pair
        for (int v = 0; v < 16; v++) begin
            a_load(4'(v));
            for (int pt = 0; pt < 4; pt++) begin
                a_p = pt[0]; a_t = pt[1];
                #1;
                chk("R7 carry", 32'(a_co), 32'((v == 15) && pt[1]));
            end
        end

        // R8: mid-cycle control changes (count is 15, enables low)
        a_p = 1'b0; a_t = 1'b0;
        a_din = 4'd3; a_load_n = 1'b0; #5; a_load_n = 1'b1;
        #5; a_p = 1'b1; a_t = 1'b1; #3; a_p = 1'b0;
        tick();
        chk("R8 between-edge glitch", 32'(a_q), 32'd15);

        // R5: mid-cycle asynchronous clear overriding load
        a_din = 4'd10; a_load_n = 1'b0; a_p = 1'b1; a_t = 1'b1;
        tick();
        chk("R4 load before clear", 32'(a_q), 32'd10);
        #5;
        a_clr_n = 1'b0; a_din = 4'd7;
        #1;
        chk("R5 immediate clear", 32'(a_q), 32'd0);
        tick();
        chk("R5 clear beats load", 32'(a_q), 32'd0);
        a_clr_n = 1'b1; a_load_n = 1'b1;
        tick();
        chk("R5 count after clear", 32'(a_q), 32'd1);

        // R6: synchronous clear waits for the edge and beats load
        s_din = 4'd12; s_load_n = 1'b0; s_p = 1'b1; s_t = 1'b1;
        tick();
        chk("R6 preload", 32'(s_q), 32'd12);
        s_clr_n = 1'b0; s_din = 4'd5;
        #5;
        chk("R6 no clear before edge", 32'(s_q), 32'd12);
        tick();
        chk("R6 clear at edge", 32'(s_q), 32'd0);
        s_clr_n = 1'b1; s_load_n = 1'b1;
        tick();
        chk("R6 count after clear", 32'(s_q), 32'd1);

        // R9: modulus-10 by decode feedback
        chk("R9 start", 32'(m_q), 32'd0);
        m_init_n = 1'b1;
        for (int i = 1; i <= 25; i++) begin
            tick();
            chk("R9 modulus", 32'(m_q), 32'(i % 10));
        end

        // R10: two-stage chain as an 8-bit counter
        c_clr_n = 1'b1; c_en = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            tick();
            chk("R10 chain value", 32'({h_q, l_q}), 32'(i % 256));
            chk("R10 chain carry", 32'(h_co), 32'((i % 256) == 255));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule